// File: doc/BRIEF.md
# Wavefront Pool Clause Dispatcher

This block is the control-flow issue stage of a SIMD compute unit. A work-group launcher adds wavefronts into a small resident pool. Each cycle the block picks one ready wavefront in round-robin order and requests its next control-flow instruction. A picked wavefront leaves the pool and does not return until that instruction is finished, so each wavefront has at most one instruction in flight and no branch prediction is needed.

The instruction memory returns a two-bit operation class for each request. Plain control instructions and global-memory writes complete as soon as they are answered. An arithmetic-clause or fetch-clause instruction must first claim its secondary engine. Each engine is a single resource. When several instructions wait for the same engine, the oldest in fetch order gets it first. The instruction then waits until that engine pulses done. Finished instructions retire strictly in fetch order. A retire that carries the end-of-program flag frees the wavefront's slot instead of returning it to the pool.

Top module: `wf_clause_dispatch`

## Requirements
- R1: After reset, no fetch, allocation or retire is signalled, `add_ready` is 1 and `add_id` is 0.
- R2: An add is taken when `add_req` and `add_ready` are both high, into the lowest-numbered free slot shown on `add_id`. With all `NUM_WF` slots occupied, `add_ready` is 0 and the add is refused.
- R3: Each cycle at most one wavefront is fetched. It is the first ready slot found by scanning cyclically upward from the slot fetched last, and after reset the scan starts at slot 0.
- R4: A fetched wavefront is not offered for fetch again until its instruction has retired.
- R5: Response class 1 asks for the arithmetic engine and class 2 for the fetch engine. An allocation is a one-cycle pulse carrying the wavefront ID, given only while that engine is idle. The engine then stays busy until its done pulse.
- R6: When several instructions wait for one engine, the oldest in fetch order is allocated first. Both engines may be allocated in the same cycle.
- R7: Response classes 0 (control) and 3 (global write) never allocate an engine. The instruction is complete in the cycle after the response.
- R8: Retire follows fetch order. A completed instruction waits behind any older one that is still incomplete, and `retire_valid` rises in the cycle after the head instruction completes.
- R9: `retire_end` repeats the end flag of the response. A retire with the flag set frees the slot for a later add; without it the wavefront returns to the ready pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| add_req | input | 1 | Launcher offers a new wavefront |
| add_ready | output | 1 | A free slot exists |
| add_id | output | ID_W | Slot that an add would take |
| fetch_valid | output | 1 | Instruction request this cycle |
| fetch_wf | output | ID_W | Wavefront being fetched |
| resp_valid | input | 1 | Instruction response |
| resp_wf | input | ID_W | Wavefront the response belongs to |
| resp_op | input | 2 | Class: 0 control, 1 arithmetic clause, 2 fetch clause, 3 global write |
| resp_end | input | 1 | Instruction ends the program |
| alu_alloc | output | 1 | Arithmetic engine allocation pulse |
| alu_wf | output | ID_W | Wavefront given the arithmetic engine |
| alu_done | input | 1 | Arithmetic clause finished |
| tex_alloc | output | 1 | Fetch engine allocation pulse |
| tex_wf | output | ID_W | Wavefront given the fetch engine |
| tex_done | input | 1 | Fetch clause finished |
| retire_valid | output | 1 | Head instruction retires |
| retire_wf | output | ID_W | Wavefront retiring |
| retire_end | output | 1 | Retired instruction ended the program |

## Verification
Several things can happen in the same cycle. A fetch, a retire, an engine done pulse, an allocation of the other engine and an add can all fall together. The heaviest case is an end-of-program retire that frees a slot in the same cycle an add is refused because the pool is full. The bench provokes these cases in two ways: directed phases that fill the pool and force every instruction onto one engine, and a long random phase with short response and engine latencies. Each cycle it compares every output against a reference model. The model applies the cycle's inputs and the expected outputs to its own slot states. A refused add must leave `add_ready` low until the cycle after the freeing retire.

// File: rtl/wfd_pkg.sv
package wfd_pkg;
   typedef enum logic [2:0] {
      SL_FREE   = 3'd0,
      SL_READY  = 3'd1,
      SL_FETCH  = 3'd2,
      SL_WAIT_A = 3'd3,
      SL_WAIT_T = 3'd4,
      SL_RUN_A  = 3'd5,
      SL_RUN_T  = 3'd6,
      SL_DONE   = 3'd7
   } slot_st_e;

   localparam logic [1:0] OP_CTRL   = 2'd0;
   localparam logic [1:0] OP_ARITH  = 2'd1;
   localparam logic [1:0] OP_TFETCH = 2'd2;
   localparam logic [1:0] OP_GWRITE = 2'd3;

   localparam int ENG_ARITH  = 0;
   localparam int ENG_TFETCH = 1;
   localparam int NUM_ENG    = 2;

   function automatic slot_st_e state_after_resp(input logic [1:0] op);
      case (op)
         OP_ARITH:  return SL_WAIT_A;
         OP_TFETCH: return SL_WAIT_T;
         default:   return SL_DONE;
      endcase
   endfunction
endpackage

// File: rtl/wfd_rr_pick.sv
module wfd_rr_pick #(
   parameter int N = 8,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] last,
   output logic          valid,
   output logic [IW-1:0] pick
);
   generate
      if (N < 2) begin : g_bad_n
         $error("wfd_rr_pick: N must be at least 2");
      end
   endgenerate

   always_comb begin
      int t;
      valid = 1'b0;
      pick  = '0;
      for (int k = 1; k <= N; k++) begin
         t = int'(last) + k;
         if (t >= N) t = t - N;
         if (!valid && req[t]) begin
            valid = 1'b1;
            pick  = IW'(t);
         end
      end
   end
endmodule

// File: rtl/wfd_order_q.sv
module wfd_order_q #(
   parameter int N  = 8,
   parameter int NM = 2,
   localparam int IW = $clog2(N),
   localparam int CW = IW + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   push,
   input  logic [IW-1:0]          push_id,
   input  logic                   pop,
   input  logic [NM-1:0][N-1:0]   match,
   output logic                   nonempty,
   output logic [IW-1:0]          head_id,
   output logic [NM-1:0]          hit,
   output logic [NM-1:0][IW-1:0]  hit_id
);
   generate
      if ((N & (N - 1)) != 0) begin : g_bad_pow2
         $error("wfd_order_q: N must be a power of two");
      end
   endgenerate

   logic [IW-1:0] mem [N];
   logic [IW-1:0] head;
   logic [CW-1:0] count;
   logic [IW-1:0] tail;

   assign tail     = head + count[IW-1:0];
   assign nonempty = (count != '0);
   assign head_id  = mem[head];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         count <= '0;
      end else begin
         if (pop) head <= head + IW'(1);
         count <= count + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[tail] <= push_id;
   end

   // Oldest-first search, one per match class
   for (genvar m = 0; m < NM; m++) begin : g_srch
      logic          h;
      logic [IW-1:0] hid;
      always_comb begin
         logic [IW-1:0] idx;
         h   = 1'b0;
         hid = '0;
         for (int k = 0; k < N; k++) begin
            idx = head + IW'(k);
            if (!h && (k < int'(count)) && match[m][mem[idx]]) begin
               h   = 1'b1;
               hid = mem[idx];
            end
         end
      end
      assign hit[m]    = h;
      assign hit_id[m] = hid;
   end

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      push && !pop |-> count < CW'(N));
   p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> count != '0);
endmodule

// File: rtl/wfd_engine.sv
module wfd_engine #(
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc,
   input  logic [IW-1:0] alloc_id,
   input  logic          done,
   output logic          busy,
   output logic [IW-1:0] owner
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         owner <= '0;
      end else if (alloc) begin
         busy  <= 1'b1;
         owner <= alloc_id;
      end else if (done) begin
         busy  <= 1'b0;
      end
   end

   p_alloc_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !busy);
   p_done_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   p_owner_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> busy && $stable(owner));
endmodule

// File: rtl/wf_clause_dispatch.sv
module wf_clause_dispatch import wfd_pkg::*; #(
   parameter int NUM_WF = 8,
   localparam int ID_W = $clog2(NUM_WF)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            add_req,
   output logic            add_ready,
   output logic [ID_W-1:0] add_id,
   output logic            fetch_valid,
   output logic [ID_W-1:0] fetch_wf,
   input  logic            resp_valid,
   input  logic [ID_W-1:0] resp_wf,
   input  logic [1:0]      resp_op,
   input  logic            resp_end,
   output logic            alu_alloc,
   output logic [ID_W-1:0] alu_wf,
   input  logic            alu_done,
   output logic            tex_alloc,
   output logic [ID_W-1:0] tex_wf,
   input  logic            tex_done,
   output logic            retire_valid,
   output logic [ID_W-1:0] retire_wf,
   output logic            retire_end
);
   generate
      if (NUM_WF < 2 || (NUM_WF & (NUM_WF - 1)) != 0) begin : g_bad_num
         $error("wf_clause_dispatch: NUM_WF must be a power of two >= 2");
      end
   endgenerate

   slot_st_e                          st [NUM_WF];
   logic [NUM_WF-1:0]                 endf;
   logic [NUM_WF-1:0]                 ready_vec, free_vec;
   logic [NUM_ENG-1:0][NUM_WF-1:0]    wait_vec;
   logic [ID_W-1:0]                   last_pick;
   logic                              add_fire;

   logic [NUM_ENG-1:0]                eng_alloc, eng_done, eng_busy, q_hit;
   logic [NUM_ENG-1:0][ID_W-1:0]      eng_wf, eng_own, q_hit_id;
   logic                              q_nonempty;
   logic [ID_W-1:0]                   q_head;

   for (genvar i = 0; i < NUM_WF; i++) begin : g_vec
      assign ready_vec[i]            = (st[i] == SL_READY);
      assign free_vec[i]             = (st[i] == SL_FREE);
      assign wait_vec[ENG_ARITH][i]  = (st[i] == SL_WAIT_A);
      assign wait_vec[ENG_TFETCH][i] = (st[i] == SL_WAIT_T);
   end

   // Lowest free slot for the launcher
   always_comb begin
      add_id = '0;
      for (int k = NUM_WF - 1; k >= 0; k--) begin
         if (free_vec[k]) add_id = ID_W'(k);
      end
   end
   assign add_ready = |free_vec;
   assign add_fire  = add_req && add_ready;

   // Round-robin fetch selection
   wfd_rr_pick #(.N(NUM_WF)) u_pick (
      .req   (ready_vec),
      .last  (last_pick),
      .valid (fetch_valid),
      .pick  (fetch_wf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           last_pick <= ID_W'(NUM_WF - 1);
      else if (fetch_valid) last_pick <= fetch_wf;
   end

   // Fetch-order queue: allocation age and retire order
   wfd_order_q #(.N(NUM_WF), .NM(NUM_ENG)) u_order (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (fetch_valid),
      .push_id  (fetch_wf),
      .pop      (retire_valid),
      .match    (wait_vec),
      .nonempty (q_nonempty),
      .head_id  (q_head),
      .hit      (q_hit),
      .hit_id   (q_hit_id)
   );

   // Secondary engines
   assign eng_done[ENG_ARITH]  = alu_done;
   assign eng_done[ENG_TFETCH] = tex_done;

   for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
      assign eng_alloc[e] = q_hit[e] && !eng_busy[e];
      assign eng_wf[e]    = q_hit_id[e];
      wfd_engine #(.IW(ID_W)) u_eng (
         .clk      (clk),
         .rst_n    (rst_n),
         .alloc    (eng_alloc[e]),
         .alloc_id (eng_wf[e]),
         .done     (eng_done[e]),
         .busy     (eng_busy[e]),
         .owner    (eng_own[e])
      );
   end

   assign alu_alloc = eng_alloc[ENG_ARITH];
   assign alu_wf    = eng_wf[ENG_ARITH];
   assign tex_alloc = eng_alloc[ENG_TFETCH];
   assign tex_wf    = eng_wf[ENG_TFETCH];

   // In-order completion
   assign retire_valid = q_nonempty && (st[q_head] == SL_DONE);
   assign retire_wf    = q_head;
   assign retire_end   = endf[q_head];

   // Per-slot lifecycle; every event targets a distinct state
   for (genvar i = 0; i < NUM_WF; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st[i]   <= SL_FREE;
            endf[i] <= 1'b0;
         end else if (add_fire && add_id == ID_W'(i)) begin
            st[i] <= SL_READY;
         end else if (fetch_valid && fetch_wf == ID_W'(i)) begin
            st[i] <= SL_FETCH;
         end else if (resp_valid && resp_wf == ID_W'(i) && st[i] == SL_FETCH) begin
            st[i]   <= state_after_resp(resp_op);
            endf[i] <= resp_end;
         end else if (alu_alloc && alu_wf == ID_W'(i)) begin
            st[i] <= SL_RUN_A;
         end else if (tex_alloc && tex_wf == ID_W'(i)) begin
            st[i] <= SL_RUN_T;
         end else if (alu_done && st[i] == SL_RUN_A && eng_own[ENG_ARITH] == ID_W'(i)) begin
            st[i] <= SL_DONE;
         end else if (tex_done && st[i] == SL_RUN_T && eng_own[ENG_TFETCH] == ID_W'(i)) begin
            st[i] <= SL_DONE;
         end else if (retire_valid && q_head == ID_W'(i)) begin
            st[i] <= retire_end ? SL_FREE : SL_READY;
         end
      end
   end

   p_resp_fetched_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> st[resp_wf] == SL_FETCH);
   p_alloc_distinct_r6: assert property (@(posedge clk) disable iff (!rst_n)
      alu_alloc && tex_alloc |-> alu_wf != tex_wf);
   p_fetch_not_retiring_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid && retire_valid |-> fetch_wf != retire_wf);
   p_freed_not_fetched_r9: assert property (@(posedge clk) disable iff (!rst_n)
      retire_valid && retire_end |=> !fetch_valid || fetch_wf != $past(retire_wf));
endmodule

// File: tb/wf_clause_dispatch_test.sv
module wf_clause_dispatch_test;
   localparam int N  = 8;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          add_req = 1'b0, resp_valid = 1'b0, resp_end = 1'b0;
   logic [IW-1:0] resp_wf = '0;
   logic [1:0]    resp_op = '0;
   logic          alu_done = 1'b0, tex_done = 1'b0;
   logic          add_ready, fetch_valid, alu_alloc, tex_alloc, retire_valid, retire_end;
   logic [IW-1:0] add_id, fetch_wf, alu_wf, tex_wf, retire_wf;

   wf_clause_dispatch #(.NUM_WF(N)) uut (
      .clk(clk), .rst_n(rst_n),
      .add_req(add_req), .add_ready(add_ready), .add_id(add_id),
      .fetch_valid(fetch_valid), .fetch_wf(fetch_wf),
      .resp_valid(resp_valid), .resp_wf(resp_wf), .resp_op(resp_op), .resp_end(resp_end),
      .alu_alloc(alu_alloc), .alu_wf(alu_wf), .alu_done(alu_done),
      .tex_alloc(tex_alloc), .tex_wf(tex_wf), .tex_done(tex_done),
      .retire_valid(retire_valid), .retire_wf(retire_wf), .retire_end(retire_end)
   );

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   // Reference model: 0 free,1 ready,2 fetched,3 wait arith,4 wait fetch-eng,5 run arith,6 run fetch-eng,7 done
   int m_st [N];
   bit m_end [N];
   int m_q [$];
   int m_last = N - 1;
   bit m_busy [2];
   int m_own [2];
   int rsp_tmr [N];
   int eng_tmr [2];

   int k_add = 0, k_lat = 0, k_end = 0, k_op = -1, k_eng = 1;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_add();
      for (int i = 0; i < N; i++) if (m_st[i] == 0) return i;
      return -1;
   endfunction

   function automatic int exp_fetch();
      for (int k = 1; k <= N; k++) begin
         int t = (m_last + k) % N;
         if (m_st[t] == 1) return t;
      end
      return -1;
   endfunction

   function automatic int exp_alloc(input int e);
      if (m_busy[e]) return -1;
      foreach (m_q[j]) if (m_st[m_q[j]] == 3 + e) return m_q[j];
      return -1;
   endfunction

   function automatic int exp_retire();
      if (m_q.size() > 0 && m_st[m_q[0]] == 7) return m_q[0];
      return -1;
   endfunction

   task automatic step();
      int ea, ef, er, rsel;
      int eal [2];
      bit dn [2];
      bit ad;
      @(negedge clk);
      ea = exp_add(); ef = exp_fetch(); er = exp_retire();
      eal[0] = exp_alloc(0); eal[1] = exp_alloc(1);
      chk("R2", "add_ready", add_ready, ea >= 0);
      if (ea >= 0) chk("R2", "add_id", add_id, ea);
      chk("R3/R4", "fetch_valid", fetch_valid, ef >= 0);
      if (ef >= 0) chk("R3/R4", "fetch_wf", fetch_wf, ef);
      chk("R5/R7", "alu_alloc", alu_alloc, eal[0] >= 0);
      if (eal[0] >= 0) chk("R6", "alu_wf", alu_wf, eal[0]);
      chk("R5/R7", "tex_alloc", tex_alloc, eal[1] >= 0);
      if (eal[1] >= 0) chk("R6", "tex_wf", tex_wf, eal[1]);
      chk("R8", "retire_valid", retire_valid, er >= 0);
      if (er >= 0) begin
         chk("R8", "retire_wf", retire_wf, er);
         chk("R9", "retire_end", retire_end, m_end[er]);
      end
      // choose inputs for this cycle
      ad = ($urandom_range(99) < k_add);
      rsel = -1;
      for (int i = 0; i < N; i++) if (rsel < 0 && m_st[i] == 2 && rsp_tmr[i] == 0) rsel = i;
      for (int e = 0; e < 2; e++) dn[e] = m_busy[e] && eng_tmr[e] == 0;
      add_req    = ad;
      resp_valid = (rsel >= 0);
      resp_wf    = (rsel >= 0) ? IW'(rsel) : '0;
      resp_op    = 2'((k_op < 0) ? $urandom_range(3) : k_op);
      resp_end   = ($urandom_range(99) < k_end);
      alu_done   = dn[0];
      tex_done   = dn[1];
      // advance the model as of the coming edge
      for (int i = 0; i < N; i++) if (m_st[i] == 2 && i != rsel && rsp_tmr[i] > 0) rsp_tmr[i]--;
      for (int e = 0; e < 2; e++) if (m_busy[e] && !dn[e]) eng_tmr[e]--;
      if (ad && ea >= 0) m_st[ea] = 1;
      if (ef >= 0) begin
         m_st[ef] = 2; m_q.push_back(ef); m_last = ef;
         rsp_tmr[ef] = $urandom_range(k_lat);
      end
      if (rsel >= 0) begin
         m_st[rsel] = (resp_op == 2'd1) ? 3 : (resp_op == 2'd2) ? 4 : 7;
         m_end[rsel] = resp_end;
      end
      for (int e = 0; e < 2; e++) begin
         if (dn[e]) begin m_st[m_own[e]] = 7; m_busy[e] = 0; end
         if (eal[e] >= 0) begin
            m_st[eal[e]] = 5 + e; m_busy[e] = 1; m_own[e] = eal[e];
            eng_tmr[e] = $urandom_range(k_eng);
         end
      end
      if (er >= 0) begin
         m_st[er] = m_end[er] ? 0 : 1;
         void'(m_q.pop_front());
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < N; i++) begin m_st[i] = 0; m_end[i] = 0; rsp_tmr[i] = 0; end
      m_busy[0] = 0; m_busy[1] = 0; m_own[0] = 0; m_own[1] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1", "fetch_valid", fetch_valid, 0);
      chk("R1", "retire_valid", retire_valid, 0);
      chk("R1", "alu_alloc", alu_alloc, 0);
      chk("R1", "tex_alloc", tex_alloc, 0);
      chk("R1", "add_ready", add_ready, 1);
      chk("R1", "add_id", add_id, 0);
      rst_n = 1'b1;
      // Fill past capacity with long latency: refusal when full (R2)
      k_add = 100; k_lat = 20; k_end = 0; k_op = 0;
      repeat (40) step();
      // Every instruction on the arithmetic engine: oldest-first contention (R6)
      k_add = 0; k_lat = 2; k_op = 1; k_eng = 6;
      repeat (120) step();
      // Fetch-engine contention
      k_op = 2; k_eng = 3;
      repeat (80) step();
      // Global writes only: no engine use (R7)
      k_op = 3; k_lat = 1;
      repeat (60) step();
      // Random mix with program ends and relaunches (R9)
      k_add = 40; k_lat = 4; k_end = 30; k_op = -1; k_eng = 4;
      repeat (3000) step();
      // Back-to-back everything
      k_add = 90; k_lat = 0; k_end = 50; k_eng = 0;
      repeat (500) step();
      // Drain: all programs end
      k_add = 0; k_end = 100; k_lat = 1; k_eng = 1;
      repeat (200) step();
      @(negedge clk);
      chk("R9", "drained add_ready", add_ready, 1);
      chk("R9", "drained add_id", add_id, 0);
      chk("R3", "drained fetch_valid", fetch_valid, 0);
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_run++; n_fail++;
         $display("FAIL R3 watchdog: actual %0d expected %0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule